// File: doc/BRIEF.md
# External Interrupt Controller

The controller gathers 64 interrupt inputs and reduces them to a single upstream request line and a status word naming the source to service. Software programs it through a 32-bit register port with a plain write strobe and a combinational read. Each source has two configuration words. The first holds an enable field, a sense-type field and a stored destination tag. The second holds an 8-bit priority. Two global bits gate the block: one gates detection and one gates the upstream request.

Most sources are level-high inputs. A window of four sources, 47 through 50, can also be set active-low, rising-edge or falling-edge. An edge sets a latch, and the latch stays set until software clears it by writing the low nibble of the source number to a shared clear register. Among the sources that are enabled and pending, the one with the largest priority value wins. The status register reports its number in the top byte, or 63 when none is pending.

Top module: `xint_ctrl`

## Requirements
- R1: The configuration words sit at 0x200+8*n (word A) and 0x204+8*n (word B) for n = 0..63. Every bit written to them reads back unchanged.
- R2: A source counts only when bits 29:28 of its word A are both 1. Any other value of that field (00, 01, 10) disables it.
- R3: For sources 47..50, bits 25:24 of word A select the sense: 0 = active-low level, 1 = active-high level, 2 = falling edge, 3 = rising edge.
- R4: Every source outside 47..50 acts as an active-high level input, whatever value its sense field holds.
- R5: An edge latch stays set after its input returns to idle. A write to 0x0C0 with bit 8 = 1 clears the latch of the edge-capable source whose number's low four bits equal data bits 3:0 (47→F, 48→0, 49→1, 50→2). A write with bit 8 = 0 leaves the latch alone. If an edge and a clear arrive in the same cycle, the edge wins.
- R6: Reads of 0x144 return the selected source number in bits 31:24 and zero in bits 23:0. Bits 31:24 read 63 when no source is pending.
- R7: The selected source is the enabled pending source with the largest priority (bits 7:0 of word B). Ties go to the lower source number.
- R8: While bit 0 at 0x004 is 0, no source is pending, no edge latch sets, and irq_out is low.
- R9: irq_out is high exactly when some source is pending, detection is on, and bit 0 at 0x444 is 1.
- R10: After reset, all configuration words, both global bits and all edge latches are zero, the status reads 63 and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| src_in | input | 64 | Interrupt source inputs, synchronous to clk |
| irq_out | output | 1 | Upstream interrupt request |

## Verification
Directed cases cover each sense type on the edge-capable window: level low, a rising edge held past the input's return, a falling edge, and an edge while detection is off. These show whether the latch, the polarity and the gate each do their own job. A sense value written to an ordinary source tells the edge-capable window apart from the rest. Each clear is tried twice, with and without bit 8, so a clear that ignores the qualifier is caught. Random phases load random enables, sense codes and priorities drawn from a small range, which forces many ties, with random input vectors. These separate highest-priority-wins from lowest-index-wins, and they show whether an enable code of 01 or 10 leaks through.

// File: rtl/xint_ctrl.sv
module xint_ctrl #(
  parameter int N_SRC   = 64,
  parameter int AW      = 12,
  parameter int EDGE_LO = 47,
  parameter int EDGE_N  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [N_SRC-1:0] src_in,
  output logic             irq_out
);
  localparam int IDW = $clog2(N_SRC);
  localparam logic [IDW-1:0] IDLE = IDW'(N_SRC - 1);
  localparam logic [AW-1:0] A_DET = AW'(12'h004);
  localparam logic [AW-1:0] A_CLR = AW'(12'h0C0);
  localparam logic [AW-1:0] A_STS = AW'(12'h144);
  localparam logic [AW-1:0] A_OEN = AW'(12'h444);

  logic [31:0] cfg_a [N_SRC];
  logic [31:0] cfg_b [N_SRC];
  logic det_en, out_en;
  logic [EDGE_N-1:0] edge_q, prev_q;
  logic [N_SRC-1:0] pend;
  logic [IDW-1:0] best_id;
  logic [7:0] best_pr;
  logic found;

  wire sel_cfg = (addr[AW-1:IDW+3] == 1);
  wire [IDW-1:0] cidx = addr[3 +: IDW];
  wire clr_wr = wr_en && addr == A_CLR && wdata[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) begin
        cfg_a[i] <= '0;
        cfg_b[i] <= '0;
      end
      det_en <= 1'b0;
      out_en <= 1'b0;
    end else if (wr_en) begin
      if (sel_cfg && addr[2]) cfg_b[cidx] <= wdata;
      if (sel_cfg && !addr[2]) cfg_a[cidx] <= wdata;
      if (addr == A_DET) det_en <= wdata[0];
      if (addr == A_OEN) out_en <= wdata[0];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    wire en = &cfg_a[i][29:28];
    if (i >= EDGE_LO && i < EDGE_LO + EDGE_N) begin : g_edge
      localparam int K = i - EDGE_LO;
      wire [1:0] sv = cfg_a[i][25:24];
      wire rise = src_in[i] && !prev_q[K];
      wire fall = !src_in[i] && prev_q[K];
      wire set_e = det_en && ((sv == 2'd3 && rise) || (sv == 2'd2 && fall));
      wire clr_e = clr_wr && wdata[3:0] == 4'(i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          edge_q[K] <= 1'b0;
          prev_q[K] <= 1'b0;
        end else begin
          prev_q[K] <= src_in[i];
          if (set_e) edge_q[K] <= 1'b1;
          else if (clr_e) edge_q[K] <= 1'b0;
        end
      end
      wire act = (sv == 2'd0) ? !src_in[i] : (sv == 2'd1) ? src_in[i] : edge_q[K];
      assign pend[i] = det_en && en && act;
    end else begin : g_lvl
      assign pend[i] = det_en && en && src_in[i];
    end
  end

  always_comb begin
    best_id = IDLE;
    best_pr = '0;
    found   = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && (!found || cfg_b[i][7:0] > best_pr)) begin
        best_id = IDW'(i);
        best_pr = cfg_b[i][7:0];
        found   = 1'b1;
      end
    end
  end

  assign irq_out = found && out_en;

  always_comb begin
    rdata = '0;
    if (sel_cfg) rdata = addr[2] ? cfg_b[cidx] : cfg_a[cidx];
    else if (addr == A_DET) rdata = {31'b0, det_en};
    else if (addr == A_OEN) rdata = {31'b0, out_en};
    else if (addr == A_STS) rdata = {8'(best_id), 24'b0};
  end
endmodule

module xint_ctrl_chk #(
  parameter int AW     = 12,
  parameter int EDGE_N = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irq_out,
  input logic              det_en,
  input logic              out_en,
  input logic [EDGE_N-1:0] edge_q
);
  p_out_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (det_en && out_en));

  p_det_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |-> !irq_out);

  p_status_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(12'h144)) |-> (rdata[23:0] == 24'd0));

  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q[0] && !(wr_en && addr == AW'(12'h0C0) && wdata[8] && wdata[3:0] == 4'hF))
      |=> edge_q[0]);

  p_cfg_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[AW-1:9] == 1) |=> ((addr != $past(addr)) || (rdata == $past(wdata))));
endmodule

bind xint_ctrl xint_ctrl_chk #(.AW(AW), .EDGE_N(EDGE_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq_out(irq_out), .det_en(det_en), .out_en(out_en),
  .edge_q(edge_q)
);

// File: tb/sim_xint_ctrl.sv
module sim_xint_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [63:0] src = '0;
  logic irq_out;

  int n_chk = 0, n_bad = 0;
  logic [31:0] ma [64];
  logic [31:0] mb [64];
  logic m_det = 1'b0, m_oen = 1'b0;
  logic [3:0] lat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xint_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                .rdata(rdata), .src_in(src), .irq_out(irq_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model();
    logic f = 1'b0;
    logic [7:0] bp = '0;
    logic [5:0] id = 6'd63;
    for (int i = 0; i < 64; i++) begin
      logic a;
      logic [1:0] sv = ma[i][25:24];
      if (i >= 47 && i <= 50)
        a = (sv == 2'd0) ? !src[i] : (sv == 2'd1) ? src[i] : lat[i-47];
      else a = src[i];
      if (m_det && ma[i][29:28] == 2'b11 && a && (!f || mb[i][7:0] > bp)) begin
        f = 1'b1; bp = mb[i][7:0]; id = 6'(i);
      end
    end
    return {f, 2'b0, id};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[11:9] == 3'b001) begin
      if (a[2]) mb[a[8:3]] = d; else ma[a[8:3]] = d;
    end
    if (a == 12'h004) m_det = d[0];
    if (a == 12'h444) m_oen = d[0];
  endtask

  task automatic chk_stat(input string req);
    logic [8:0] m = model();
    addr = 12'h144; #1;
    check(req, rdata, {m[7:0], 24'b0});
    check(req, 32'(irq_out), 32'(m[8] && m_oen));
  endtask

  function automatic logic [11:0] ca(input int n, input bit b);
    return 12'h200 + 12'(8*n) + (b ? 12'd4 : 12'd0);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin ma[i] = '0; mb[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk_stat("R10");
    addr = ca(63, 1); #1; check("R10", rdata, 32'h0);
    addr = 12'h004; #1; check("R10", rdata, 32'h0);
    wr(12'h004, 1); wr(12'h444, 1);
    // R1 readback
    wr(ca(5, 0), 32'hA5C3_1F7E); wr(ca(63, 1), 32'h1234_5678);
    addr = ca(5, 0); #1; check("R1", rdata, 32'hA5C3_1F7E);
    addr = ca(63, 1); #1; check("R1", rdata, 32'h1234_5678);
    wr(ca(5, 0), 0); wr(ca(63, 1), 0);
    // R2 partial enable codes
    src[5] = 1'b1;
    wr(ca(5, 0), 32'h1000_0000); chk_stat("R2");
    wr(ca(5, 0), 32'h2000_0000); chk_stat("R2");
    wr(ca(5, 0), 32'h3000_0000); chk_stat("R2");
    check("R2", rdata, 32'h0500_0000);
    wr(ca(5, 0), 0); src[5] = 1'b0;
    // R3 level low on 48
    wr(ca(48, 0), 32'h3000_0000); chk_stat("R3");
    check("R3", rdata, 32'h3000_0000);
    src[48] = 1'b1; @(negedge clk); chk_stat("R3");
    wr(ca(48, 0), 0); src[48] = 1'b0;
    // R4 sense field ignored outside the window
    wr(ca(10, 0), 32'h3000_0000); src[10] = 1'b0; chk_stat("R4");
    wr(ca(10, 0), 32'h3300_0000); src[10] = 1'b1; @(negedge clk); chk_stat("R4");
    check("R4", rdata, 32'h0A00_0000);
    src[10] = 1'b0; @(negedge clk); chk_stat("R4");
    wr(ca(10, 0), 0);
    // R3 R5 rising edge on 49
    wr(ca(49, 0), 32'h3300_0000);
    src[49] = 1'b1; @(negedge clk); lat[2] = 1'b1; chk_stat("R3");
    check("R3", rdata, 32'h3100_0000);
    src[49] = 1'b0; @(negedge clk); chk_stat("R5");
    wr(12'h0C0, 32'h0000_0001); chk_stat("R5");
    check("R5", rdata, 32'h3100_0000);
    wr(12'h0C0, 32'h0000_0101); lat[2] = 1'b0; chk_stat("R5");
    wr(ca(49, 0), 0);
    // R3 R5 falling edge on 47
    src[47] = 1'b1; wr(ca(47, 0), 32'h3200_0000);
    src[47] = 1'b0; @(negedge clk); lat[0] = 1'b1; chk_stat("R3");
    check("R3", rdata, 32'h2F00_0000);
    wr(12'h0C0, 32'h0000_010F); lat[0] = 1'b0; chk_stat("R5");
    wr(ca(47, 0), 0);
    // R8 no latching while detection off
    wr(ca(50, 0), 32'h3300_0000); wr(12'h004, 0);
    src[50] = 1'b1; @(negedge clk); chk_stat("R8");
    wr(12'h004, 1); chk_stat("R8");
    check("R8", rdata, 32'h3F00_0000);
    src[50] = 1'b0; wr(ca(50, 0), 0);
    // R7 priority and ties
    wr(ca(3, 0), 32'h3000_0000); wr(ca(3, 1), 5);
    wr(ca(20, 0), 32'h3000_0000); wr(ca(20, 1), 5);
    wr(ca(40, 0), 32'h3000_0000); wr(ca(40, 1), 2);
    src[3] = 1'b1; src[20] = 1'b1; src[40] = 1'b1; @(negedge clk);
    chk_stat("R7"); check("R7", rdata, 32'h0300_0000);
    wr(ca(40, 1), 9); chk_stat("R7"); check("R7", rdata, 32'h2800_0000);
    // R8 level source with detection off
    wr(12'h004, 0); chk_stat("R8"); check("R8", 32'(irq_out), 0);
    wr(12'h004, 1);
    // R9 output gate
    wr(12'h444, 0); chk_stat("R9"); check("R9", 32'(irq_out), 0);
    check("R9", rdata, 32'h2800_0000);
    wr(12'h444, 1); chk_stat("R9"); check("R9", 32'(irq_out), 1);
    // random phase
    for (int i = 47; i <= 50; i++) wr(ca(i, 0), 0);
    for (int it = 0; it < 400; it++) begin
      int j = $urandom_range(0, 63);
      logic [31:0] a = {2'b0, 2'($urandom), 2'b0, 2'($urandom), 16'b0, 8'($urandom)};
      if (j >= 47 && j <= 50) a[25] = 1'b0;
      wr(ca(j, 0), a);
      wr(ca(j, 1), {24'($urandom), 5'b0, 3'($urandom)});
      src = {$urandom, $urandom};
      @(negedge clk);
      chk_stat("R7");
      addr = ca(j, 0); #1; check("R1", rdata, ma[j]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule